// File: doc/BRIEF.md
# Physical-Address Memory-Type Resolver

This block answers one question per request: which memory type governs a given 4 KB page of physical address space? It reads the address, the global and fixed-region enables, the default type, a table of 88 one-byte fixed-region types and a set of variable base/mask pairs. It returns the 8-bit type one clock after the request strobe.

Below 1 MB, and only when fixed-region lookup is enabled, a three-tier map picks one byte of the fixed table. The tiers are coarse in the lowest half-megabyte, medium in the next quarter and fine in the top quarter. Everywhere else, every enabled variable pair is compared against the page. Overlapping hits are merged under a fixed precedence, and a page that no pair covers takes the default type. Clearing the global enable forces the uncacheable type for every page.

Typical use is next to a page-walk or translation unit, which presents one page per request and consumes the type with a single-cycle latency.

Top module: `mtr_resolver`

## Requirements
- R1: `rsp_valid` equals `req_valid` delayed by one clock. While reset is asserted, and right after it, `rsp_valid` and `rsp_type` are 0.
- R2: If `glb_en` is 0, the type returned is 0 (uncacheable) for every address.
- R3: Fixed entry n occupies `fix_tbl[8n+7:8n]`. Addresses 0x00000–0x7FFFF select entry addr>>16 (0..7). Addresses 0x80000–0xBFFFF select entry 8+((addr−0x80000)>>14) (8..23). Addresses 0xC0000–0xFFFFF select entry 24+((addr−0xC0000)>>12) (24..87).
- R4: The fixed table is consulted only when `fix_en` is 1 and the address is below 0x100000. Otherwise only the variable pairs decide.
- R5: Pair i occupies bits [PA_W·i +: PA_W] of `var_base` and `var_mask`. It takes part only when bit 11 of its mask is 1. It covers a page when the base and the address agree on every address bit from 12 upward where the mask is 1. Its type is base bits 7:0.
- R6: When all covering pairs carry the same type, that type is returned.
- R7: When any covering pair has type 0, the result is 0.
- R8: When the covering pairs carry only types 4 and 6, and both occur, the result is 4.
- R9: Any other disagreement between covering pairs resolves to 6.
- R10: When no enabled pair covers the page, the result is `dflt_type`.
- R11: Address bits 11:0 have no influence on the result.
- R12: In a cycle without a request, `rsp_type` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | PA_W | Physical address; bits 11:0 ignored |
| glb_en | input | 1 | Global enable of all range registers |
| fix_en | input | 1 | Enable of the fixed sub-1 MB map |
| dflt_type | input | 8 | Type for uncovered pages |
| fix_tbl | input | 704 | 88 fixed entries, one byte each |
| var_base | input | N_VAR·PA_W | Variable bases, type in bits 7:0 |
| var_mask | input | N_VAR·PA_W | Variable masks, enable in bit 11 |
| rsp_valid | output | 1 | Result strobe |
| rsp_type | output | 8 | Resolved memory type |

## Verification
The checker assumes that the configuration inputs are stable from the cycle of a request until its result appears. It also assumes that `req_valid` is never X once reset is released. The bench changes the configuration only on falling edges between requests, and it keeps the strobe driven at all times. For overlap cases, the bench places variable ranges on naturally aligned power-of-two boundaries, so that each mask describes a contiguous region whose coverage the bench can compute with plain comparisons.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    localparam int TW          = 8;
    localparam int FIX_ENTRIES = 88;
    localparam int PAGE_SHIFT  = 12;
    localparam int VLD_BIT     = 11;
    localparam int LOW_SHIFT   = 20;   // fixed map spans the first 1 MB
    localparam int IDX_W       = $clog2(FIX_ENTRIES);

    localparam logic [TW-1:0] MT_UC = 8'd0;
    localparam logic [TW-1:0] MT_WT = 8'd4;
    localparam logic [TW-1:0] MT_WB = 8'd6;

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] mtype;
    } rsp_t;
endpackage

// File: rtl/mtr_fixed_lookup.sv
module mtr_fixed_lookup
    import mtr_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [PA_W-1:0]           addr,
    input  logic [FIX_ENTRIES*TW-1:0] fix_tbl,
    output logic                      in_low,
    output logic [TW-1:0]             ftype
);
    localparam int S0_BASE = 0;   // 64 KB tier
    localparam int S1_BASE = 8;   // 16 KB tier
    localparam int S2_BASE = 24;  // 4 KB tier

    logic [IDX_W-1:0] idx;

    assign in_low = (addr[PA_W-1:LOW_SHIFT] == '0);

    always_comb begin
        if (!addr[19])
            idx = IDX_W'(S0_BASE) + IDX_W'(addr[18:16]);
        else if (!addr[18])
            idx = IDX_W'(S1_BASE) + IDX_W'(addr[17:14]);
        else
            idx = IDX_W'(S2_BASE) + IDX_W'(addr[17:12]);
    end

    always_comb begin
        ftype = '0;
        for (int n = 0; n < FIX_ENTRIES; n++)
            if (idx == IDX_W'(n))
                ftype = fix_tbl[n*TW +: TW];
    end
endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match
    import mtr_pkg::*;
#(
    parameter int PN_W = 24
) (
    input  logic [PN_W-1:0] pfn,
    input  logic [PN_W-1:0] base_pfn,
    input  logic [PN_W-1:0] mask_pfn,
    input  logic            enabled,
    input  logic [TW-1:0]   base_type,
    output logic            hit,
    output logic [TW-1:0]   vtype
);
    assign hit   = enabled && (((pfn ^ base_pfn) & mask_pfn) == '0);
    assign vtype = base_type;
endmodule

// File: rtl/mtr_type_merge.sv
module mtr_type_merge
    import mtr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]    hits,
    input  logic [N*TW-1:0] types,
    input  logic [TW-1:0]   dflt,
    output logic [TW-1:0]   mtype
);
    logic          any_hit, has_uc, all_same, only_wtwb;
    logic [TW-1:0] first_t;

    always_comb begin
        first_t = '0;
        for (int i = N-1; i >= 0; i--)
            if (hits[i]) first_t = types[i*TW +: TW];
    end

    always_comb begin
        any_hit   = |hits;
        has_uc    = 1'b0;
        all_same  = 1'b1;
        only_wtwb = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                if (types[i*TW +: TW] == MT_UC)   has_uc   = 1'b1;
                if (types[i*TW +: TW] != first_t) all_same = 1'b0;
                if (types[i*TW +: TW] != MT_WT && types[i*TW +: TW] != MT_WB)
                    only_wtwb = 1'b0;
            end
        end
    end

    always_comb begin
        if (!any_hit)       mtype = dflt;
        else if (has_uc)    mtype = MT_UC;
        else if (all_same)  mtype = first_t;
        else if (only_wtwb) mtype = MT_WT;
        else                mtype = MT_WB;
    end
endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int N_VAR = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [PA_W-1:0]           req_addr,
    input  logic                      glb_en,
    input  logic                      fix_en,
    input  logic [TW-1:0]             dflt_type,
    input  logic [FIX_ENTRIES*TW-1:0] fix_tbl,
    input  logic [N_VAR*PA_W-1:0]     var_base,
    input  logic [N_VAR*PA_W-1:0]     var_mask,
    output logic                      rsp_valid,
    output logic [TW-1:0]             rsp_type
);
    localparam int PN_W = PA_W - PAGE_SHIFT;

    logic                  in_low;
    logic [TW-1:0]         fix_type, var_type, res_type;
    logic [N_VAR-1:0]      vhit;
    logic [N_VAR*TW-1:0]   vtypes;
    rsp_t                  st_d, st_q;

    mtr_fixed_lookup #(.PA_W(PA_W)) u_fixed (
        .addr    (req_addr),
        .fix_tbl (fix_tbl),
        .in_low  (in_low),
        .ftype   (fix_type)
    );

    for (genvar i = 0; i < N_VAR; i++) begin : g_pair
        mtr_var_match #(.PN_W(PN_W)) u_match (
            .pfn       (req_addr[PA_W-1:PAGE_SHIFT]),
            .base_pfn  (var_base[i*PA_W+PAGE_SHIFT +: PN_W]),
            .mask_pfn  (var_mask[i*PA_W+PAGE_SHIFT +: PN_W]),
            .enabled   (var_mask[i*PA_W+VLD_BIT]),
            .base_type (var_base[i*PA_W +: TW]),
            .hit       (vhit[i]),
            .vtype     (vtypes[i*TW +: TW])
        );
    end

    mtr_type_merge #(.N(N_VAR)) u_merge (
        .hits  (vhit),
        .types (vtypes),
        .dflt  (dflt_type),
        .mtype (var_type)
    );

    always_comb begin
        if (!glb_en)                res_type = MT_UC;
        else if (fix_en && in_low)  res_type = fix_type;
        else                        res_type = var_type;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) st_d.mtype = res_type;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_type  = st_q.mtype;
endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk
    import mtr_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int N_VAR = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [PA_W-1:0]       req_addr,
    input logic                  glb_en,
    input logic                  fix_en,
    input logic [TW-1:0]         dflt_type,
    input logic [N_VAR*PA_W-1:0] var_mask,
    input logic                  rsp_valid,
    input logic [TW-1:0]         rsp_type
);
    logic no_pair_on;
    always_comb begin
        no_pair_on = 1'b1;
        for (int i = 0; i < N_VAR; i++)
            if (var_mask[i*PA_W+VLD_BIT]) no_pair_on = 1'b0;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    assert_disabled_uc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glb_en) |=> rsp_type == MT_UC);

    assert_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && glb_en && no_pair_on &&
         !(fix_en && req_addr[PA_W-1:LOW_SHIFT] == '0))
        |=> rsp_type == $past(dflt_type));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_type));
endmodule

bind mtr_resolver mtr_resolver_chk #(.PA_W(PA_W), .N_VAR(N_VAR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .glb_en    (glb_en),
    .fix_en    (fix_en),
    .dflt_type (dflt_type),
    .var_mask  (var_mask),
    .rsp_valid (rsp_valid),
    .rsp_type  (rsp_type)
);

// File: tb/test_mtr_resolver.sv
module test_mtr_resolver;
    localparam int AW = 24;
    localparam int NV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic              glb_en = 1'b0, fix_en = 1'b0;
    logic [7:0]        dflt_type = 8'd0;
    logic [88*8-1:0]   fix_tbl;
    logic [NV*AW-1:0]  var_base, var_mask;
    logic              rsp_valid;
    logic [7:0]        rsp_type;

    logic [7:0]        fixtbl [88];
    logic [AW-1:0]     vb [NV];
    logic [AW-1:0]     vm [NV];

    int nvec = 0, nerr = 0;

    always #2 clk = ~clk;

    for (genvar n = 0; n < 88; n++) begin : g_ft
        assign fix_tbl[n*8 +: 8] = fixtbl[n];
    end
    for (genvar i = 0; i < NV; i++) begin : g_vr
        assign var_base[i*AW +: AW] = vb[i];
        assign var_mask[i*AW +: AW] = vm[i];
    end

    mtr_resolver #(.PA_W(AW), .N_VAR(NV)) i_mtr_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .glb_en(glb_en), .fix_en(fix_en), .dflt_type(dflt_type),
        .fix_tbl(fix_tbl), .var_base(var_base), .var_mask(var_mask),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    function automatic logic [7:0] ref_type(input logic [AW-1:0] a);
        int idx, nhit, n_uc, n_wt, n_wb;
        logic [7:0] t0;
        logic mixed;
        if (!glb_en) return 8'd0;
        if (fix_en && a < 24'h100000) begin
            if (a < 24'h80000)      idx = int'(a) / 65536;
            else if (a < 24'hC0000) idx = 8 + (int'(a) - 'h80000) / 16384;
            else                    idx = 24 + (int'(a) - 'hC0000) / 4096;
            return fixtbl[idx];
        end
        nhit = 0; n_uc = 0; n_wt = 0; n_wb = 0; mixed = 1'b0; t0 = 8'd0;
        for (int i = 0; i < NV; i++) begin
            if (vm[i][11] && ((a >> 12) & (vm[i] >> 12)) == ((vb[i] >> 12) & (vm[i] >> 12))) begin
                if (nhit == 0) t0 = vb[i][7:0];
                else if (vb[i][7:0] != t0) mixed = 1'b1;
                nhit++;
                if (vb[i][7:0] == 8'd0) n_uc++;
                if (vb[i][7:0] == 8'd4) n_wt++;
                if (vb[i][7:0] == 8'd6) n_wb++;
            end
        end
        if (nhit == 0) return dflt_type;
        if (n_uc > 0)  return 8'd0;
        if (!mixed)    return t0;
        if (n_wt + n_wb == nhit) return 8'd4;
        return 8'd6;
    endfunction

    task automatic fail_line(input string tag, input logic [AW-1:0] a,
                             input logic [7:0] got, input logic [7:0] exp);
        nerr++;
        $display("FAIL %s addr=%h type=%0d expected=%0d", tag, a, got, exp);
    endtask

    task automatic apply(input logic [AW-1:0] a, input string tag);
        logic [7:0] e;
        e = ref_type(a);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nvec++;
        if (rsp_valid !== 1'b1) begin
            nerr++;
            $display("FAIL R1 addr=%h valid=%b expected=1", a, rsp_valid);
        end else if (rsp_type !== e) fail_line(tag, a, rsp_type, e);
    endtask

    // place a naturally aligned region of 2^lg bytes
    task automatic set_pair(input int i, input logic [AW-1:0] start, input int lg,
                            input logic [7:0] t, input logic on);
        vb[i] = start | AW'(t);
        vm[i] = (~((AW'(1) << lg) - AW'(1))) & ~AW'(12'hFFF);
        vm[i][11] = on;
    endtask

    initial begin
        logic [7:0] tv [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
        for (int n = 0; n < 88; n++) fixtbl[n] = 8'((n * 13 + 7) & 255);
        for (int i = 0; i < NV; i++) begin vb[i] = '0; vm[i] = '0; end

        repeat (3) @(negedge clk);
        nvec++;  // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_type !== 8'd0) begin
            nerr++;
            $display("FAIL R1 reset valid=%b type=%0d expected 0/0", rsp_valid, rsp_type);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every fixed page, with junk low bits (R11)
        glb_en = 1'b1; fix_en = 1'b1; dflt_type = 8'd5;
        set_pair(0, 24'h000000, 20, 8'd1, 1'b1);  // overlaps low MB; must be ignored
        for (int p = 0; p < 256; p++)
            apply(AW'(p << 12) | AW'((p * 677) & 12'hFFF), "R3/R11");

        // R4: fixed disabled -> low MB handled by pairs / default
        fix_en = 1'b0;
        for (int p = 0; p < 256; p += 7) apply(AW'(p << 12), "R4");
        vm[0][11] = 1'b0;
        for (int p = 0; p < 256; p += 5) apply(AW'(p << 12), "R4/R10");

        // R5-R10: two overlapping pairs, every type combination
        set_pair(2, 24'h400000, 20, 8'd6, 1'b0);   // disabled pair, R5
        for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++) begin
                set_pair(0, 24'h100000, 20, tv[x], 1'b1);
                set_pair(1, 24'h180000, 18, tv[y], 1'b1);
                for (logic [AW-1:0] a = 24'h0F0000; a < 24'h208000; a += 24'h8000)
                    apply(a | AW'(x * 291 + y), "R5-merge(R6/R7/R8/R9/R10)");
                apply(24'h400000, "R5");
            end

        // three-way overlap with a third enabled pair
        for (int x = 0; x < 5; x++) begin
            set_pair(0, 24'h100000, 20, 8'd4, 1'b1);
            set_pair(1, 24'h180000, 18, 8'd6, 1'b1);
            set_pair(3, 24'h1A0000, 16, tv[x], 1'b1);
            for (logic [AW-1:0] a = 24'h198000; a < 24'h1C0000; a += 24'h4000)
                apply(a, "R7/R8/R9");
        end

        // R10: enabled pairs elsewhere, default on uncovered pages
        for (int k = 0; k < 16; k++) apply(24'h800000 + AW'(k << 16), "R10");

        // R2: global disable
        glb_en = 1'b0; fix_en = 1'b1;
        for (int k = 0; k < 24; k++) apply(AW'(k * 24'h0A3000), "R2");
        glb_en = 1'b1;

        // R12: output holds with no request
        apply(24'h180000, "R12 setup");
        begin
            logic [7:0] held;
            held = rsp_type;
            req_addr = 24'h900000;
            repeat (3) @(negedge clk);
            nvec++;
            if (rsp_valid !== 1'b0 || rsp_type !== held) begin
                nerr++;
                $display("FAIL R12 type=%0d expected=%0d valid=%b", rsp_type, held, rsp_valid);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule